// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits beside the storage array of a byte-wide parallel flash device. It watches the host write strobes (active-low chip enable, write enable and output enable), the 19-bit address and the 8-bit data bus. It recognises the multi-cycle unlock sequences the host uses to request work from the device. When a sequence completes, it raises a one-clock request to the array engine: program one byte, erase the whole chip, or set the boot-region lock. It also enters and leaves an identification mode. In that mode it replaces array read data with fixed identification bytes and the current lock status.

The strobes are sampled on a system clock, and strobe edges are found by comparing each sample with the previous one. A bus write opens when chip enable and write enable are both seen low while output enable is high. The address is latched at that moment. The write closes when either strobe returns high, and the data last seen during the pulse is taken as the written byte. Each closed write advances the sequence state machine by one step. Any write that does not match the expected next step sends the state machine back to idle without a request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in normal read mode (`idMode` = 0), no request is asserted, and `rdData` equals `arrayData`.
- R2: A bus write is counted only while `ceN` and `weN` are both low with `oeN` high. A pulse on `ceN` alone with `weN` high has no effect. A pulse with `oeN` low has no effect.
- R3: The address of a write is the value present when both strobes were first seen low. The data of a write is the last value seen before either strobe returns high.
- R4: The writes AA@5555, 55@2AAA, A0@5555, followed by any byte D to any address T, produce a single `progReq` pulse with `progAddr` = T and `progData` = D.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 produce a single `eraseReq` pulse.
- R6: The same six-write prefix ending in 40@5555 instead of 10@5555 produces a single `lockReq` pulse.
- R7: Command writes compare only address bits 14..0, so bits 18..15 may take any value.
- R8: AA@5555, 55@2AAA, 90@5555 sets `idMode`. `idMode` is cleared by AA@5555, 55@2AAA, F0@5555, or by a single F0 written to any address from idle.
- R9: While `idMode` is 1, `rdData` reads 0x1F at address 0, 0x13 at address 1, and {7'b0, `bootLocked`} at address 2. It reads 0x00 at every other address.
- R10: A write that does not match the expected next step returns the decoder to idle with no request. The write after it is then treated as the start of a new sequence.
- R11: Every request lasts exactly one clock and appears two clocks after the strobe rise is sampled. At most one request is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 19 | Bus address |
| wrData | input | 8 | Bus write data |
| arrayData | input | 8 | Read data from the storage array |
| bootLocked | input | 1 | Current boot-region lock state |
| rdData | output | 8 | Read data toward the bus drivers |
| idMode | output | 1 | Identification mode is active |
| progReq | output | 1 | One-clock byte program request |
| progAddr | output | 19 | Target address of the program request |
| progData | output | 8 | Byte to program |
| eraseReq | output | 1 | One-clock chip erase request |
| lockReq | output | 1 | One-clock boot lock request |

## Verification
Assertions check on every cycle that requests are mutually exclusive and last one clock, and that every request and every change of `idMode` follows a closed bus write. Closed write events are also checked never to come in adjacent cycles. Only the bench scenarios can show that the correct sequence leads to the correct request. The same applies to aborts after a wrong step, masking of the upper address bits, the latching points of address and data, the blocking effect of output enable, and the identification read values.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMP_W  = 15;
  localparam int BYTE_W = 8;

  localparam logic [CMP_W-1:0]  UNLOCK_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0]  UNLOCK_ADDR_B = 15'h2AAA;
  localparam logic [BYTE_W-1:0] KEY_FIRST     = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_SECOND    = 8'h55;
  localparam logic [BYTE_W-1:0] OP_PROGRAM    = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_ERASE_PRE  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_ID_ENTER   = 8'h90;
  localparam logic [BYTE_W-1:0] OP_ID_LEAVE   = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_CHIP_ERASE = 8'h10;
  localparam logic [BYTE_W-1:0] OP_BOOT_LOCK  = 8'h40;
  localparam logic [BYTE_W-1:0] ID_MAKER      = 8'h1F;
  localparam logic [BYTE_W-1:0] ID_PART       = 8'h13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3
  } cmdState_t;

  typedef struct packed {
    logic              wrStb;
    logic              hitA;
    logic              hitB;
    logic [BYTE_W-1:0] data;
  } wrEvt_t;
endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              bootLocked,
  input  logic              idMode,
  output wrEvt_t            evt,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W = ADDR_W - 2;

  logic              ceS, weS, oeS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  logic              activeQ;
  logic              active;
  logic              startEv;
  logic              endEv;
  logic [DATA_W-1:0] idByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceS   <= 1'b1;
      weS   <= 1'b1;
      oeS   <= 1'b1;
      addrS <= '0;
      dataS <= '0;
    end else begin
      ceS   <= ceN;
      weS   <= weN;
      oeS   <= oeN;
      addrS <= addr;
      dataS <= wrData;
    end
  end

  assign active  = !ceS && !weS && oeS;
  assign startEv = active && !activeQ;
  // A pulse closes cleanly only when a strobe returns high with output enable still high.
  assign endEv   = activeQ && !active && oeS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      capAddr <= '0;
      capData <= '0;
    end else begin
      activeQ <= active;
      if (startEv) capAddr <= addrS;
      if (active)  capData <= dataS;
    end
  end

  assign evt.wrStb = endEv;
  assign evt.hitA  = (capAddr[CMP_W-1:0] == UNLOCK_ADDR_A);
  assign evt.hitB  = (capAddr[CMP_W-1:0] == UNLOCK_ADDR_B);
  assign evt.data  = capData[BYTE_W-1:0];

  always_comb begin
    idByte = '0;
    if (addr[ADDR_W-1:2] == HI_W'(0)) begin
      case (addr[1:0])
        2'd0:    idByte = ID_MAKER;
        2'd1:    idByte = ID_PART;
        2'd2:    idByte = DATA_W'(bootLocked);
        default: idByte = '0;
      endcase
    end
  end

  assign rdData = idMode ? idByte : arrayData;

  // R11
  wr_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrStb |=> !evt.wrStb);
  // R2
  wr_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrStb |-> $past(!ceS && !weS));
endmodule

// File: rtl/flash_cmd_control.sv
module flash_cmd_control
  import flash_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  wrEvt_t evt,
  output logic   progReq,
  output logic   eraseReq,
  output logic   lockReq,
  output logic   idMode
);
  cmdState_t state, stateNxt;
  logic      progNxt, eraseNxt, lockNxt, idNxt;

  always_comb begin
    stateNxt = state;
    progNxt  = 1'b0;
    eraseNxt = 1'b0;
    lockNxt  = 1'b0;
    idNxt    = idMode;
    if (evt.wrStb) begin
      stateNxt = ST_IDLE;
      unique case (state)
        ST_IDLE: begin
          if (evt.hitA && evt.data == KEY_FIRST) stateNxt = ST_KEY1;
          else if (evt.data == OP_ID_LEAVE)      idNxt    = 1'b0;
        end
        ST_KEY1: if (evt.hitB && evt.data == KEY_SECOND) stateNxt = ST_KEY2;
        ST_KEY2: if (evt.hitA) begin
          case (evt.data)
            OP_PROGRAM:   stateNxt = ST_PROG;
            OP_ERASE_PRE: stateNxt = ST_ERS1;
            OP_ID_ENTER:  idNxt    = 1'b1;
            OP_ID_LEAVE:  idNxt    = 1'b0;
            default:      stateNxt = ST_IDLE;
          endcase
        end
        ST_PROG: progNxt = 1'b1;
        ST_ERS1: if (evt.hitA && evt.data == KEY_FIRST)  stateNxt = ST_ERS2;
        ST_ERS2: if (evt.hitB && evt.data == KEY_SECOND) stateNxt = ST_ERS3;
        ST_ERS3: if (evt.hitA) begin
          eraseNxt = (evt.data == OP_CHIP_ERASE);
          lockNxt  = (evt.data == OP_BOOT_LOCK);
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      progReq  <= 1'b0;
      eraseReq <= 1'b0;
      lockReq  <= 1'b0;
      idMode   <= 1'b0;
    end else begin
      state    <= stateNxt;
      progReq  <= progNxt;
      eraseReq <= eraseNxt;
      lockReq  <= lockNxt;
      idMode   <= idNxt;
    end
  end

  // R11
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, eraseReq, lockReq}));
  // R11
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    progReq |=> !progReq);
  // R4
  prog_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> $past(evt.wrStb));
  // R5
  erase_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eraseReq || lockReq) |-> $past(evt.wrStb && evt.hitA));
  // R8
  id_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idMode) |-> $past(evt.wrStb && evt.data == OP_ID_ENTER));
  // R8
  id_leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idMode) |-> $past(evt.wrStb && evt.data == OP_ID_LEAVE));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              bootLocked,
  output logic [DATA_W-1:0] rdData,
  output logic              idMode,
  output logic              progReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic              eraseReq,
  output logic              lockReq
);
  wrEvt_t evt;

  flash_cmd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .arrayData(arrayData),
    .bootLocked(bootLocked), .idMode(idMode), .evt(evt),
    .capAddr(progAddr), .capData(progData), .rdData(rdData)
  );

  flash_cmd_control u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt),
    .progReq(progReq), .eraseReq(eraseReq), .lockReq(lockReq),
    .idMode(idMode)
  );
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  arrayData = 8'h5A;
  logic        bootLocked = 1'b0;
  logic [7:0]  rdData;
  logic        idMode, progReq, eraseReq, lockReq;
  logic [18:0] progAddr;
  logic [7:0]  progData;

  int nChecks = 0, nFails = 0;
  int progCnt = 0, eraseCnt = 0, lockCnt = 0;
  logic [18:0] lastAddr;
  logic [7:0]  lastData;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .arrayData(arrayData),
    .bootLocked(bootLocked), .rdData(rdData), .idMode(idMode),
    .progReq(progReq), .progAddr(progAddr), .progData(progData),
    .eraseReq(eraseReq), .lockReq(lockReq)
  );

  always @(negedge clk) begin
    if (progReq) begin
      progCnt++;
      lastAddr = progAddr;
      lastData = progData;
    end
    if (eraseReq) eraseCnt++;
    if (lockReq)  lockCnt++;
  end

  // {addr, data, pulse kind (0 none, 1 prog, 2 erase, 3 lock), idMode after}
  localparam int NV = 40;
  localparam logic [29:0] VEC [NV] = '{
    {19'h05555, 8'hAA, 2'd0, 1'b0},  // R4 program
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'hA0, 2'd0, 1'b0},
    {19'h12345, 8'h3C, 2'd1, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},  // R5 erase
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'h80, 2'd0, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'h10, 2'd2, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},  // R6 lock
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'h80, 2'd0, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'h40, 2'd3, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},  // R8 enter
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'h90, 2'd0, 1'b1},
    {19'h7ABCD, 8'hF0, 2'd0, 1'b0},  // R8 single-write leave
    {19'h45555, 8'hAA, 2'd0, 1'b0},  // R7 upper bits ignored
    {19'h32AAA, 8'h55, 2'd0, 1'b0},
    {19'h75555, 8'h90, 2'd0, 1'b1},
    {19'h05555, 8'hAA, 2'd0, 1'b1},  // R8 three-write leave
    {19'h02AAA, 8'h55, 2'd0, 1'b1},
    {19'h05555, 8'hF0, 2'd0, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},  // R10 bad second address
    {19'h02AAB, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'hA0, 2'd0, 1'b0},
    {19'h00100, 8'h00, 2'd0, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},  // R10 bad last byte
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'h80, 2'd0, 1'b0},
    {19'h05555, 8'hAA, 2'd0, 1'b0},
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'h20, 2'd0, 1'b0},
    {19'h45555, 8'hAA, 2'd0, 1'b0},  // R7 program with high bits
    {19'h02AAA, 8'h55, 2'd0, 1'b0},
    {19'h05555, 8'hA0, 2'd0, 1'b0},
    {19'h7FFFF, 8'h00, 2'd1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [18:0] a, input logic [7:0] d,
                          input bit oeLow, input bit ceOnly);
    @(negedge clk);
    addr = a; wrData = d; oeN = !oeLow;
    ceN = 1'b0;
    if (!ceOnly) weN = 1'b0;
    repeat (3) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
    oeN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic readCheck(input logic [18:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    check(rdData == exp, req, rdData, exp);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({idMode, progReq, eraseReq, lockReq} == 4'b0, "R1",
          {idMode, progReq, eraseReq, lockReq}, 0);
    check(rdData == arrayData, "R1", rdData, arrayData);

    for (int i = 0; i < NV; i++) begin
      int p0, e0, l0;
      logic [1:0] kind;
      p0 = progCnt; e0 = eraseCnt; l0 = lockCnt;
      kind = VEC[i][2:1];
      busWrite(VEC[i][29:11], VEC[i][10:3], 1'b0, 1'b0);
      // R11: exactly one pulse per completed command
      check({progCnt - p0 == (kind == 2'd1), eraseCnt - e0 == (kind == 2'd2),
             lockCnt - l0 == (kind == 2'd3), idMode == VEC[i][0]} == 4'hF,
            $sformatf("R%0d vec %0d", (kind == 2'd0) ? 10 : 3 + kind, i),
            {progCnt - p0, eraseCnt - e0, lockCnt - l0, idMode},
            {kind, VEC[i][0]});
      if (kind == 2'd1)
        check(lastAddr == VEC[i][29:11] && lastData == VEC[i][10:3], "R4",
              {lastAddr, lastData}, VEC[i][29:3]);
    end

    // R9 identification reads
    busWrite(19'h05555, 8'hAA, 0, 0);
    busWrite(19'h02AAA, 8'h55, 0, 0);
    busWrite(19'h05555, 8'h90, 0, 0);
    check(idMode == 1'b1, "R8", idMode, 1);
    readCheck(19'h00000, 8'h1F, "R9");
    readCheck(19'h00001, 8'h13, "R9");
    readCheck(19'h00002, 8'h00, "R9");
    bootLocked = 1'b1;
    readCheck(19'h00002, 8'h01, "R9");
    readCheck(19'h00003, 8'h00, "R9");
    readCheck(19'h40000, 8'h00, "R9");

    // R2 blocked writes leave identification mode set
    busWrite(19'h00000, 8'hF0, 1'b1, 1'b0);
    check(idMode == 1'b1, "R2 oe low", idMode, 1);
    busWrite(19'h00000, 8'hF0, 1'b0, 1'b1);
    check(idMode == 1'b1, "R2 ce only", idMode, 1);
    busWrite(19'h00000, 8'hF0, 1'b0, 1'b0);
    check(idMode == 1'b0, "R8", idMode, 0);
    readCheck(19'h00000, arrayData, "R9 normal");

    // R3 address latched at start, data at end of pulse
    begin
      int p0;
      busWrite(19'h05555, 8'hAA, 0, 0);
      busWrite(19'h02AAA, 8'h55, 0, 0);
      busWrite(19'h05555, 8'hA0, 0, 0);
      p0 = progCnt;
      @(negedge clk);
      addr = 19'h0ABCD; wrData = 8'h11; ceN = 1'b0; weN = 1'b0;
      repeat (2) @(negedge clk);
      addr = 19'h54321; wrData = 8'h77;
      repeat (2) @(negedge clk);
      ceN = 1'b1;
      repeat (4) @(negedge clk);
      weN = 1'b1;
      repeat (2) @(negedge clk);
      check(progCnt - p0 == 1, "R3 count", progCnt - p0, 1);
      check(lastAddr == 19'h0ABCD, "R3 addr", lastAddr, 19'h0ABCD);
      check(lastData == 8'h77, "R3 data", lastData, 8'h77);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule